// File: doc/BRIEF.md
# Separable Ternary Basis Vector Generator

This block produces a pair of one-dimensional ternary basis vectors, one for the rows and one for the columns of an N-point square array. Each element is +1, -1 or 0, where 0 marks a sample that takes no part in the weighted sum. The row and column vectors are chosen independently, so their outer product defines a separable two-dimensional pattern. A Haar pair gives the scaling pattern or one subband cell of a dyadic decomposition; a Walsh pair gives one of the full-array patterns used for compressive measurements.

A start strobe launches one vector pair. The basis family is shared by both axes, and the row and column indices come either from the request or from an internal 16-bit maximal-length LFSR when random selection is requested. The two vectors leave as a lock-step serial stream, one element pair per accepted beat, with valid and last flags. The stream is meant to be shifted into a row select register and a column select register.

Top module: `sbg_gen`

## Requirements
- R1: While reset is held and whenever no vector is being streamed, valid and last are low and both element outputs are 2'b00.
- R2: Elements use the codes 2'b00 for zero, 2'b01 for +1 and 2'b11 for -1; the code 2'b10 never appears on a valid beat.
- R3: In Haar mode (basis_sel = 0), index 0 gives +1 at every position.
- R4: In Haar mode, an index i from 1 to N-1 has level j = floor(log2 i), offset p = i - 2^j and support length L = N/2^j. Position k is +1 for p*L <= k < p*L+L/2, -1 for p*L+L/2 <= k < (p+1)*L, and 0 elsewhere. The row and column vectors each follow their own index.
- R5: In Walsh mode (basis_sel = 1), position k of index i is -1 when popcount(i & k) is odd and +1 otherwise; no element is zero.
- R6: A start taken while idle raises valid on the next cycle. Positions are emitted from N-1 down to 0, one per cycle in which valid and ready are both high. While ready is low, the outputs hold.
- R7: last is high exactly on the beat carrying position 0. valid falls in the cycle after that beat is accepted.
- R8: A start seen while valid is high is ignored: the stream in progress and the LFSR state are unchanged.
- R9: With rand_sel = 1 at an accepted start, the row index is taken from LFSR bits [IW-1:0] and the column index from bits [2*IW-1:IW], where IW = log2 N. The LFSR then steps once: next = {s[14:0], s[15]^s[13]^s[12]^s[10]}. Its reset state is 16'hACE1.
- R10: seed_wr loads seed_val into the LFSR, and a zero seed is replaced by 16'h0001. A load in the same cycle as a random start wins over the step, while the start still uses the old state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Launch one vector pair when idle |
| basis_sel | input | 1 | 0 = Haar, 1 = Walsh |
| rand_sel | input | 1 | Take both indices from the LFSR |
| row_idx | input | IW | Row vector index |
| col_idx | input | IW | Column vector index |
| seed_wr | input | 1 | Load the LFSR seed |
| seed_val | input | 16 | Seed value |
| ready | input | 1 | Consumer accepts the current beat |
| valid | output | 1 | Beat present |
| last | output | 1 | Beat carries position 0 |
| row_elem | output | 2 | Row element code |
| col_elem | output | 2 | Column element code |

## Verification
A corrupted position counter shows up on the first mismatching beat: a skipped or repeated position moves the Haar support edges or flips a Walsh sign, and a wrong terminal count moves last or the fall of valid. A stale captured index or basis bit corrupts the whole burst from its first beat. A wrong LFSR tap or step count appears only on the next random start, so random starts are issued back to back to expose a bad LFSR within one vector.

// File: rtl/sbg_pkg.sv
package sbg_pkg;

   localparam int LFSR_W = 16;
   localparam logic [LFSR_W-1:0] LFSR_INIT = 16'hACE1;

   typedef enum logic [1:0] {
      TRI_ZERO = 2'b00,
      TRI_POS  = 2'b01,
      TRI_NEG  = 2'b11
   } tri_t;

   typedef enum logic {
      BASIS_HAAR  = 1'b0,
      BASIS_WALSH = 1'b1
   } basis_e;

endpackage

// File: rtl/sbg_lfsr.sv
module sbg_lfsr
   import sbg_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [LFSR_W-1:0] seed,
   input  logic              step,
   output logic [LFSR_W-1:0] state
);

   logic feedback;

   assign feedback = state[15] ^ state[13] ^ state[12] ^ state[10];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= LFSR_INIT;
      end else if (load) begin
         state <= (seed == '0) ? LFSR_W'(1) : seed;
      end else if (step) begin
         state <= {state[LFSR_W-2:0], feedback};
      end
   end

endmodule

// File: rtl/sbg_seq.sv
module sbg_seq #(
   parameter int N  = 128,
   localparam int IW = $clog2(N)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          launch,
   input  logic          ready,
   output logic          busy,
   output logic [IW-1:0] pos,
   output logic          at_end
);

   localparam logic [IW-1:0] POS_TOP = IW'(N - 1);

   assign at_end = busy && (pos == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy <= 1'b0;
         pos  <= '0;
      end else if (!busy) begin
         if (launch) begin
            busy <= 1'b1;
            pos  <= POS_TOP;
         end
      end else if (ready) begin
         if (pos == '0) begin
            busy <= 1'b0;
         end else begin
            pos <= pos - IW'(1);
         end
      end
   end

endmodule

// File: rtl/sbg_elem.sv
module sbg_elem
   import sbg_pkg::*;
#(
   parameter int IW = 7
) (
   input  basis_e        basis,
   input  logic [IW-1:0] idx,
   input  logic [IW-1:0] pos,
   output tri_t          code
);

   int            lvl;
   logic [IW-1:0] blk;
   logic [IW-1:0] mask;
   logic          half;
   tri_t          haar_code;
   tri_t          walsh_code;

   always_comb begin
      lvl = 0;
      for (int b = 0; b < IW; b++) begin
         if (idx[b]) lvl = b;
      end
      blk  = pos >> (IW - lvl);
      mask = (IW'(1) << lvl) - IW'(1);
      half = pos[IW-1-lvl];
      if (idx == '0) begin
         haar_code = TRI_POS;
      end else if (blk == (idx & mask)) begin
         haar_code = half ? TRI_NEG : TRI_POS;
      end else begin
         haar_code = TRI_ZERO;
      end
      walsh_code = (^(idx & pos)) ? TRI_NEG : TRI_POS;
   end

   assign code = (basis == BASIS_WALSH) ? walsh_code : haar_code;

endmodule

// File: rtl/sbg_gen.sv
module sbg_gen
   import sbg_pkg::*;
#(
   parameter int N  = 128,
   localparam int IW = $clog2(N)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              basis_sel,
   input  logic              rand_sel,
   input  logic [IW-1:0]     row_idx,
   input  logic [IW-1:0]     col_idx,
   input  logic              seed_wr,
   input  logic [LFSR_W-1:0] seed_val,
   input  logic              ready,
   output logic              valid,
   output logic              last,
   output logic [1:0]        row_elem,
   output logic [1:0]        col_elem
);

   localparam int AXES = 2;

   if (N < 2 || N > 128 || (N & (N - 1)) != 0) begin : g_bad_n
      $error("sbg_gen: N must be a power of two from 2 to 128");
   end
   if (2 * IW > LFSR_W) begin : g_bad_w
      $error("sbg_gen: LFSR too narrow for two indices");
   end

   logic                     busy;
   logic                     launch;
   logic [IW-1:0]            pos;
   logic                     at_end;
   logic [LFSR_W-1:0]        lfsr_state;
   logic                     unused_lfsr_bits;
   basis_e                   basis_q;
   logic [AXES-1:0][IW-1:0]  idx_q;
   logic [AXES-1:0][IW-1:0]  idx_req;
   logic [AXES-1:0][IW-1:0]  idx_rnd;
   tri_t [AXES-1:0]          code;

   assign launch           = start && !busy;
   assign idx_req[0]       = row_idx;
   assign idx_req[1]       = col_idx;
   assign unused_lfsr_bits = ^lfsr_state;

   for (genvar a = 0; a < AXES; a++) begin : g_rnd
      assign idx_rnd[a] = lfsr_state[a*IW +: IW];
   end

   sbg_lfsr u_lfsr (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (seed_wr),
      .seed  (seed_val),
      .step  (launch && rand_sel),
      .state (lfsr_state)
   );

   sbg_seq #(.N(N)) u_seq (
      .clk    (clk),
      .rst_n  (rst_n),
      .launch (launch),
      .ready  (ready),
      .busy   (busy),
      .pos    (pos),
      .at_end (at_end)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         basis_q <= BASIS_HAAR;
         idx_q   <= '0;
      end else if (launch) begin
         basis_q <= basis_e'(basis_sel);
         idx_q   <= rand_sel ? idx_rnd : idx_req;
      end
   end

   for (genvar a = 0; a < AXES; a++) begin : g_axis
      sbg_elem #(.IW(IW)) u_elem (
         .basis (basis_q),
         .idx   (idx_q[a]),
         .pos   (pos),
         .code  (code[a])
      );
   end

   assign valid    = busy;
   assign last     = at_end;
   assign row_elem = busy ? code[0] : TRI_ZERO;
   assign col_elem = busy ? code[1] : TRI_ZERO;

endmodule

// File: rtl/sbg_checker.sv
module sbg_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       start,
   input logic       basis_sel,
   input logic       ready,
   input logic       valid,
   input logic       last,
   input logic [1:0] row_elem,
   input logic [1:0] col_elem
);

   logic walsh_q;

   always_ff @(posedge clk) begin
      if (!rst_n) walsh_q <= 1'b0;
      else if (start && !valid) walsh_q <= basis_sel;
   end

   assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !valid |-> (row_elem == 2'b00 && col_elem == 2'b00 && !last));

   assert_code_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
      valid |-> (row_elem != 2'b10 && col_elem != 2'b10));

   assert_walsh_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && walsh_q) |-> (row_elem != 2'b00 && col_elem != 2'b00));

   assert_launch_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !valid) |=> (valid && !last));

   assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && !ready) |=> (valid && $stable(row_elem) && $stable(col_elem) && $stable(last)));

   assert_end_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && ready && last) |=> !valid);

   assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && start && !(ready && last)) |=> valid);

endmodule

bind sbg_gen sbg_checker u_sbg_checker (.*);

// File: tb/test_sbg_gen.sv
module test_sbg_gen;

   localparam int N          = 128;
   localparam int IW         = $clog2(N);
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        basis_sel = 1'b0;
   logic        rand_sel = 1'b0;
   logic [IW-1:0] row_idx = '0;
   logic [IW-1:0] col_idx = '0;
   logic        seed_wr = 1'b0;
   logic [15:0] seed_val = '0;
   logic        ready = 1'b0;
   logic        valid;
   logic        last;
   logic [1:0]  row_elem;
   logic [1:0]  col_elem;

   int checks = 0;
   int errors = 0;
   bit done = 0;
   logic [15:0] model_lfsr = 16'hACE1;

   always #(CLK_PERIOD/2) clk = ~clk;

   sbg_gen #(.N(N)) i_sbg_gen (
      .clk(clk), .rst_n(rst_n), .start(start), .basis_sel(basis_sel),
      .rand_sel(rand_sel), .row_idx(row_idx), .col_idx(col_idx),
      .seed_wr(seed_wr), .seed_val(seed_val), .ready(ready),
      .valid(valid), .last(last), .row_elem(row_elem), .col_elem(col_elem)
   );

   function automatic logic [15:0] lfsr_next(logic [15:0] s);
      return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
   endfunction

   function automatic logic [1:0] exp_code(bit walsh, int idx, int k);
      int j, p, len, s;
      if (walsh) return ($countones(idx & k) % 2 == 1) ? 2'b11 : 2'b01;
      if (idx == 0) return 2'b01;
      j = 0;
      while ((2 << j) <= idx) j++;
      p   = idx - (1 << j);
      len = N >> j;
      s   = p * len;
      if (k >= s && k < s + len / 2) return 2'b01;
      if (k >= s + len / 2 && k < s + len) return 2'b11;
      return 2'b00;
   endfunction

   task automatic check(bit ok, string tag, string what, int act, int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
      end
   endtask

   task automatic run_vec(bit walsh, bit rnd, int ri, int ci, int ready_pct, bit poke);
      int er, ec, k;
      string tg;
      @(negedge clk);
      start = 1; basis_sel = walsh; rand_sel = rnd;
      row_idx = IW'(ri); col_idx = IW'(ci);
      if (rnd) begin
         er = int'(model_lfsr[IW-1:0]);
         ec = int'(model_lfsr[2*IW-1:IW]);
         model_lfsr = lfsr_next(model_lfsr);
      end else begin
         er = ri; ec = ci;
      end
      tg = walsh ? "R5" : "R4";
      k = N - 1;
      forever begin
         @(negedge clk);
         start = poke && ($urandom_range(0, 9) == 0);
         if (start) begin
            rand_sel = 1'b1; basis_sel = ~basis_sel;
            row_idx = IW'($urandom); col_idx = IW'($urandom);
         end
         ready = ($urandom_range(1, 100) <= ready_pct);
         #1;
         check(valid == 1'b1, "R6", "valid during burst (R8 when poked)", valid, 1);
         check(row_elem == exp_code(walsh, er, k),
               (!walsh && er == 0) ? "R3" : (rnd ? "R9" : tg),
               $sformatf("row idx %0d pos %0d", er, k), row_elem, exp_code(walsh, er, k));
         check(col_elem == exp_code(walsh, ec, k),
               (!walsh && ec == 0) ? "R3" : (rnd ? "R9" : tg),
               $sformatf("col idx %0d pos %0d", ec, k), col_elem, exp_code(walsh, ec, k));
         check(last == (k == 0), "R7", $sformatf("last at pos %0d", k), last, k == 0);
         if (ready) begin
            if (k == 0) break;
            k--;
         end
      end
      @(negedge clk);
      start = 0; ready = 0; rand_sel = 0;
      #1;
      check(valid == 1'b0, "R7", "valid falls after final beat", valid, 0);
      check(row_elem == 2'b00 && col_elem == 2'b00, "R1", "idle elements zero",
            {row_elem, col_elem}, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      #1;
      check(valid == 0 && last == 0 && row_elem == 0 && col_elem == 0, "R1",
            "outputs in reset", {valid, last, row_elem, col_elem}, 0);
      @(negedge clk);
      rst_n = 1;
      #1;
      check(valid == 0, "R1", "valid after reset", valid, 0);

      void'($urandom(32'd1234));
      // directed Haar corners (R3, R4)
      run_vec(0, 0, 0, 1, 100, 0);
      run_vec(0, 0, N - 1, N / 2, 100, 0);
      run_vec(0, 0, 3, 5, 60, 0);
      // directed Walsh corners (R5)
      run_vec(1, 0, 0, N - 1, 100, 0);
      run_vec(1, 0, 85, 42, 50, 0);
      // LFSR from reset state (R9), back to back
      run_vec(1, 1, 0, 0, 100, 0);
      run_vec(0, 1, 0, 0, 100, 0);
      // zero seed is replaced by one (R10)
      @(negedge clk);
      seed_wr = 1; seed_val = 16'h0000;
      @(negedge clk);
      seed_wr = 0;
      model_lfsr = 16'h0001;
      run_vec(1, 1, 0, 0, 100, 0);
      // load and random start in the same cycle (R10)
      @(negedge clk);
      start = 1; rand_sel = 1; basis_sel = 1;
      seed_wr = 1; seed_val = 16'hBEEF;
      @(negedge clk);
      start = 0; seed_wr = 0; ready = 1;
      #1;
      check(row_elem == exp_code(1, int'(model_lfsr[IW-1:0]), N - 1), "R10",
            "start uses pre-load state", row_elem, exp_code(1, int'(model_lfsr[IW-1:0]), N - 1));
      model_lfsr = 16'hBEEF;
      while (!last) @(negedge clk);
      @(negedge clk);
      ready = 0;
      run_vec(1, 1, 0, 0, 100, 0);
      // starts during a burst are ignored (R8)
      run_vec(0, 0, 9, 17, 70, 1);
      run_vec(1, 1, 0, 0, 70, 1);
      // random mix
      for (int n = 0; n < 40; n++) begin
         run_vec($urandom_range(0, 1), $urandom_range(0, 3) == 0,
                 $urandom_range(0, N - 1), $urandom_range(0, N - 1),
                 $urandom_range(30, 100), $urandom_range(0, 1));
      end
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog run did not finish actual=0 expected=1");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule